// File: doc/BRIEF.md
# Microcoded I2C Waveform Sequencer

This block produces I2C clock and data waveforms by playing back a table of microcode entries, not by following a hard-wired bus protocol engine. Each entry gives the levels of the two bus lines for one step, says whether the data line is sampled during that step, says whether the entry belongs to an active program, and names the entry that follows. Host software therefore decides every START, STOP, data bit and acknowledge by the entries it writes, and the block's only notion of time is a fixed step length in core clocks. The step length is chosen so that a bit, which takes three or four steps, stays within a 400 kHz bus rate.

The host writes entries one at a time through a single 32-bit program word. A start pulse runs the program from entry 0. Sampled data bits shift into a 32-bit result word, MSB first, so up to four read bytes end up right-aligned with the last byte in the low eight bits. A busy output stays high from the accepted start until the engine reaches an entry whose busy bit is clear. The bus lines are modelled as plain released-high/driven-low levels; the sampled input is the resolved data wire.

The controller has two states. `SEQ_IDLE` holds the lines and waits; the *start accepted* transition moves it to `SEQ_RUN`. In `SEQ_RUN` every step end either takes the *continue* transition (the successor entry has busy set, so it becomes the current entry) or the *halt* transition back to `SEQ_IDLE` (the successor has busy clear, and its line levels are held).

Top module: `i2c_ucode_seq`

## Requirements
- R1: After reset, scl_o and sda_o are 1, busy_o is 0, result_o is 0, and every one of the 2^ADDR_W entries holds an all-zero entry (busy 0, read-enable 0, both lines high, next address 0).
- R2: A cycle with prog_we high stores one entry at the address in prog_word bits 27:18, with bit 13 busy, bit 12 read-enable, bit 11 inverted SCL level, bit 10 inverted SDA level and bits 9:0 the next address; bits 31:28 and 17:14 are ignored.
- R3: A start pulse sampled in `SEQ_IDLE` makes busy_o 1 and result_o 0 in the next cycle, and drives the line levels of entry 0, which is always played once whatever its busy bit.
- R4: Each played entry holds its line levels for exactly STEP_CYCLES clocks, after which the entry named by its next-address field is used.
- R5: When a step ends and the successor entry has busy 0, busy_o falls in that same cycle, the lines take that successor's levels, and lines and result_o then stay unchanged until the next accepted start.
- R6: At the last clock of a step whose entry has read-enable 1, the sda_in level is shifted into result_o bit 0 while the older bits move one place up (bit 31 is lost); the new value is visible from the next cycle.
- R7: A start pulse while busy_o is 1 is ignored: the run, its timing and result_o continue unchanged.
- R8: Program writes while the engine is idle change none of scl_o, sda_o, busy_o or result_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Store the entry carried on prog_word this cycle |
| prog_word | input | 32 | Entry word: own address, busy, read-enable, inverted line levels, next address |
| start | input | 1 | Run the program from entry 0 (ignored while busy) |
| sda_in | input | 1 | Resolved level of the data wire, sampled on read steps |
| scl_o | output | 1 | Clock line level (1 = released high) |
| sda_o | output | 1 | Data line level (1 = released high) |
| busy_o | output | 1 | High while a program runs |
| result_o | output | 32 | Sampled data bits, newest in bit 0 |

## Verification
The bench plays an unprogrammed table, which separates the forced single play of entry 0 from a normal halt, then complete write transactions with START, byte bits, acknowledge release and STOP, which expose step length and chaining errors on the lines. Read transactions of four and five bytes, with a bus target model pulling the data wire low, show MSB-first shifting, right alignment and the loss of the oldest byte. Entries written with junk in the unused bits, a halt entry with unusual levels, and a start pulse during a run separate field decoding, held halt levels, and the ignore rule for a busy start.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    // Field positions inside the host program word.
    localparam int SELF_LSB = 18;
    localparam int BUSY_BIT = 13;
    localparam int RDEN_BIT = 12;
    localparam int SCLN_BIT = 11;
    localparam int SDAN_BIT = 10;

    // Control part of one microcode entry.
    typedef struct packed {
        logic busy;
        logic rd_en;
        logic scl_n;
        logic sda_n;
    } uop_ctl_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ucode_store.sv
module ucode_store
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  uop_ctl_t          wctl,
    input  logic [ADDR_W-1:0] wnext,
    input  logic [ADDR_W-1:0] raddr_a,
    output uop_ctl_t          ctl_a,
    output logic [ADDR_W-1:0] next_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output uop_ctl_t          ctl_b
);
    localparam int DEPTH = 1 << ADDR_W;

    uop_ctl_t          ctl_mem [DEPTH];
    logic [ADDR_W-1:0] nxt_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctl_mem[i] <= '0;
                nxt_mem[i] <= '0;
            end
        end else if (we) begin
            ctl_mem[waddr] <= wctl;
            nxt_mem[waddr] <= wnext;
        end
    end

    assign ctl_a  = ctl_mem[raddr_a];
    assign next_a = nxt_mem[raddr_a];
    assign ctl_b  = ctl_mem[raddr_b];

endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int STEP_CYCLES = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             bit_in,
    output logic [WIDTH-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (shift) begin
            value <= {value[WIDTH-2:0], bit_in};
        end
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step_done,
    input  uop_ctl_t          cur_ctl,
    input  logic [ADDR_W-1:0] cur_next,
    input  uop_ctl_t          succ_ctl,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] succ_addr,
    output logic              running,
    output logic              timer_clear,
    output logic              res_clr,
    output logic              res_shift,
    output logic              scl_o,
    output logic              sda_o
);
    seq_state_e        state, state_nxt;
    logic [ADDR_W-1:0] pc_nxt;
    logic              load_lines;

    // In idle the successor port looks at entry 0, so a start loads its levels.
    assign succ_addr = (state == SEQ_IDLE) ? '0 : cur_next;
    assign running   = (state == SEQ_RUN);

    always_comb begin
        state_nxt   = state;
        pc_nxt      = pc;
        load_lines  = 1'b0;
        timer_clear = 1'b0;
        res_clr     = 1'b0;
        res_shift   = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (start) begin
                    state_nxt   = SEQ_RUN;
                    pc_nxt      = '0;
                    load_lines  = 1'b1;
                    timer_clear = 1'b1;
                    res_clr     = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (step_done) begin
                    res_shift  = cur_ctl.rd_en;
                    load_lines = 1'b1;
                    if (!succ_ctl.busy) begin
                        state_nxt = SEQ_IDLE;
                    end else begin
                        pc_nxt = cur_next;
                    end
                end
            end
            default: begin
                state_nxt = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            pc    <= '0;
            scl_o <= 1'b1;
            sda_o <= 1'b1;
        end else begin
            state <= state_nxt;
            pc    <= pc_nxt;
            if (load_lines) begin
                scl_o <= ~succ_ctl.scl_n;
                sda_o <= ~succ_ctl.sda_n;
            end
        end
    end

endmodule

// File: rtl/i2c_ucode_seq.sv
module i2c_ucode_seq
    import i2cseq_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int STEP_CYCLES = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prog_we,
    input  logic [31:0] prog_word,
    input  logic        start,
    input  logic        sda_in,
    output logic        scl_o,
    output logic        sda_o,
    output logic        busy_o,
    output logic [31:0] result_o
);
    localparam int RES_W = 32;

    uop_ctl_t          w_ctl, cur_ctl, succ_ctl;
    logic [ADDR_W-1:0] w_addr, w_next, cur_next, pc, succ_addr;
    logic              step_done, running, timer_clear, res_clr, res_shift;

    // Program word decode.
    assign w_addr      = prog_word[SELF_LSB +: ADDR_W];
    assign w_next      = prog_word[ADDR_W-1:0];
    assign w_ctl.busy  = prog_word[BUSY_BIT];
    assign w_ctl.rd_en = prog_word[RDEN_BIT];
    assign w_ctl.scl_n = prog_word[SCLN_BIT];
    assign w_ctl.sda_n = prog_word[SDAN_BIT];

    ucode_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (prog_we),
        .waddr   (w_addr),
        .wctl    (w_ctl),
        .wnext   (w_next),
        .raddr_a (pc),
        .ctl_a   (cur_ctl),
        .next_a  (cur_next),
        .raddr_b (succ_addr),
        .ctl_b   (succ_ctl)
    );

    step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .run   (running),
        .done  (step_done)
    );

    seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .step_done   (step_done),
        .cur_ctl     (cur_ctl),
        .cur_next    (cur_next),
        .succ_ctl    (succ_ctl),
        .pc          (pc),
        .succ_addr   (succ_addr),
        .running     (running),
        .timer_clear (timer_clear),
        .res_clr     (res_clr),
        .res_shift   (res_shift),
        .scl_o       (scl_o),
        .sda_o       (sda_o)
    );

    result_shifter #(.WIDTH(RES_W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (res_clr),
        .shift  (res_shift),
        .bit_in (sda_in),
        .value  (result_o)
    );

    assign busy_o = running;

endmodule

// File: rtl/i2c_ucode_seq_chk.sv
module i2c_ucode_seq_chk #(
    parameter int STEP_CYCLES = 63
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        scl_o,
    input logic        sda_o,
    input logic        busy_o,
    input logic [31:0] result_o
);
    // Position inside the current step, kept independently of the design.
    int phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 0;
        end else if (!busy_o && start) begin
            phase <= 0;
        end else if (busy_o) begin
            phase <= (phase == STEP_CYCLES - 1) ? 0 : phase + 1;
        end
    end

    // R1
    reset_values_chk: assert property (@(posedge clk)
        !rst_n |=> (scl_o && sda_o && !busy_o && result_o == 32'd0));

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start) |=> (busy_o && result_o == 32'd0));

    // R4
    step_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (!$stable(scl_o) || !$stable(sda_o))) |-> (phase == 0));

    // R5
    halt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (phase == 0));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start) |=> ($stable(scl_o) && $stable(sda_o) && $stable(result_o)));

    // R6
    shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(result_o)) |-> (result_o[31:1] == $past(result_o[30:0])));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start) |=> (result_o == $past(result_o) || result_o[31:1] == $past(result_o[30:0])));

endmodule

bind i2c_ucode_seq i2c_ucode_seq_chk #(.STEP_CYCLES(STEP_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .busy_o   (busy_o),
    .result_o (result_o)
);

// File: tb/i2c_ucode_seq_tb.sv
module i2c_ucode_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 6;
    localparam int AW         = 10;
    localparam int DEPTH      = 1 << AW;
    localparam int HALT_A     = 1000;
    localparam int WATCHDOG   = 150000;

    logic        clk, rst_n, prog_we, start, slave_q;
    logic [31:0] prog_word;
    logic        scl_o, sda_o, busy_o, sda_in;
    logic [31:0] result_o;

    // Resolved data wire: either side may pull it low.
    assign sda_in = sda_o & slave_q;

    i2c_ucode_seq #(.ADDR_W(AW), .STEP_CYCLES(STEP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we),
        .prog_word (prog_word),
        .start     (start),
        .sda_in    (sda_in),
        .scl_o     (scl_o),
        .sda_o     (sda_o),
        .busy_o    (busy_o),
        .result_o  (result_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Host-side image of the table (R1: all-zero words after reset).
    logic [31:0] mirror [DEPTH];

    // Expected per-cycle stream.
    bit          q_scl[$], q_sda[$], q_busy[$], q_slave[$];
    logic [31:0] q_res[$];
    int          q_tag[$];
    bit          pat_q[$];

    bit          idle_scl = 1'b1, idle_sda = 1'b1;
    logic [31:0] idle_res = 32'd0;
    int          idle_tag = 1;
    int          override = 0;
    bit          checking = 1'b0;
    int          n_cmp = 0, n_bad = 0, cyc = 0, wp = 0;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: run did not end (got cycle %0d, expected below %0d)", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    // Per-cycle comparison against the reference stream.
    always @(negedge clk) begin
        if (checking) begin
            bit          e_scl, e_sda, e_busy, e_slave;
            logic [31:0] e_res;
            int          tag;
            if (q_busy.size() > 0) begin
                e_scl = q_scl.pop_front();  e_sda = q_sda.pop_front();
                e_busy = q_busy.pop_front(); e_slave = q_slave.pop_front();
                e_res = q_res.pop_front();  tag = q_tag.pop_front();
            end else begin
                e_scl = idle_scl; e_sda = idle_sda; e_busy = 1'b0;
                e_slave = 1'b1; e_res = idle_res; tag = idle_tag;
            end
            slave_q = e_slave;
            n_cmp++;
            if (scl_o !== e_scl || sda_o !== e_sda || busy_o !== e_busy || result_o !== e_res) begin
                if (override != 0) tag = override;
                else if (scl_o === e_scl && sda_o === e_sda && busy_o === e_busy) tag = 6;
                n_bad++;
                $display("FAIL R%0d @%0d: scl/sda/busy/result got %b %b %b %h expected %b %b %b %h",
                         tag, cyc, scl_o, sda_o, busy_o, result_o, e_scl, e_sda, e_busy, e_res);
            end
        end
    end

    // R2: word layout used by the host.
    task automatic put(input int a, input bit b, input bit rd, input bit scl, input bit sda,
                       input int nxt, input logic [31:0] junk);
        logic [31:0] w;
        w = {4'b0, a[9:0], 4'b0, b, rd, ~scl, ~sda, nxt[9:0]} | junk;
        @(posedge clk); #1;
        prog_we = 1'b1; prog_word = w;
        mirror[a] = w;
        @(posedge clk); #1;
        prog_we = 1'b0; prog_word = 32'hDEAD_BEEF;
    endtask

    logic [31:0] junk_mask = 32'd0;

    task automatic emit(input bit rd, input bit scl, input bit sda);
        put(wp, 1'b1, rd, scl, sda, wp + 1, junk_mask);
        wp++;
    endtask

    task automatic wbit(input bit v);
        emit(0, 0, v); emit(0, 1, v); emit(0, 0, v);
    endtask

    task automatic rbit();
        emit(0, 0, 1); emit(0, 1, 1); emit(1, 1, 1); emit(0, 0, 1);
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        wbit(1'b1);
    endtask

    task automatic rbyte(input bit last);
        for (int i = 0; i < 8; i++) rbit();
        wbit(last);
    endtask

    task automatic begin_prog();
        idle_tag = 8; // R8: writes while idle leave the outputs alone
        put(0, 1'b1, 1'b0, 1'b1, 1'b1, 1, junk_mask);
        wp = 1;
        emit(0, 1, 1); emit(0, 1, 0); emit(0, 0, 0); // START
    endtask

    task automatic end_prog(input bit hs, input bit hd);
        emit(0, 0, 0); emit(0, 1, 0);                  // STOP
        put(wp, 1'b1, 1'b0, 1'b1, 1'b1, HALT_A, junk_mask);
        put(HALT_A, 1'b0, 1'b0, hs, hd, HALT_A, junk_mask);
    endtask

    task automatic push_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) pat_q.push_back(v[i]);
    endtask

    task automatic push_cyc(input bit s, input bit d, input bit b, input bit sl,
                            input logic [31:0] r, input int t);
        q_scl.push_back(s); q_sda.push_back(d); q_busy.push_back(b);
        q_slave.push_back(sl); q_res.push_back(r); q_tag.push_back(t);
    endtask

    // Walk the host image and build the expected stream of a run.
    task automatic build_run();
        int          pc, n;
        logic [31:0] e, su, res;
        bit          first, pb, lvl;
        push_cyc(idle_scl, idle_sda, 1'b0, 1'b1, idle_res, idle_tag);
        pc = 0; res = 32'd0; first = 1'b1; n = 0;
        forever begin
            e  = mirror[pc];
            pb = 1'b1;
            if (e[12] && pat_q.size() > 0) pb = pat_q.pop_front();
            for (int k = 0; k < STEP; k++)
                push_cyc(~e[11], ~e[10], 1'b1, e[12] ? pb : 1'b1, res, first ? 3 : 4);
            if (e[12]) begin
                lvl = ~e[10] & pb;
                res = {res[30:0], lvl};
            end
            first = 1'b0;
            su = mirror[e[9:0]];
            n++;
            if (!su[13] || n > 4000) begin
                idle_scl = ~su[11]; idle_sda = ~su[10]; idle_res = res;
                break;
            end
            pc = int'(e[9:0]);
        end
        idle_tag = 5;
    endtask

    task automatic launch();
        @(posedge clk); #1;
        start = 1'b1;
        build_run();
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (q_busy.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic check_result(input logic [31:0] exp, input string what);
        @(negedge clk); #1;
        n_cmp++;
        if (result_o !== exp) begin
            n_bad++;
            $display("FAIL R6 %s: result got %h expected %h", what, result_o, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mirror[i] = 32'd0;
        rst_n = 1'b0; prog_we = 1'b0; prog_word = 32'd0; start = 1'b0; slave_q = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        checking = 1'b1;

        // R1: reset levels held for a while.
        repeat (8) @(posedge clk);

        // R3 / R5: untouched table plays entry 0 once, then halts on it.
        launch(); wait_done();

        // R4 / R5: write transaction, address byte then one data byte.
        begin_prog(); wbyte(8'hA6); wbyte(8'h5A); end_prog(1'b1, 1'b1);
        launch(); wait_done();

        // R6: four read bytes land right-aligned, last byte lowest.
        begin_prog(); wbyte(8'hA7);
        rbyte(0); rbyte(0); rbyte(0); rbyte(1);
        end_prog(1'b1, 1'b1);
        push_byte(8'h3C); push_byte(8'hD2); push_byte(8'h81); push_byte(8'h7E);
        launch(); wait_done();
        check_result(32'h3CD2_817E, "four bytes");

        // R6: a fifth byte pushes the oldest one out.
        begin_prog(); wbyte(8'hA7);
        rbyte(0); rbyte(0); rbyte(0); rbyte(0); rbyte(1);
        end_prog(1'b1, 1'b1);
        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33); push_byte(8'h44); push_byte(8'h55);
        launch(); wait_done();
        check_result(32'h2233_4455, "five bytes");

        // R3: the next run clears the result; R7: a start during it is ignored.
        begin_prog(); wbyte(8'h3E); end_prog(1'b1, 1'b1);
        launch();
        repeat (25) @(posedge clk);
        #1 override = 7; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait_done();
        override = 0;
        check_result(32'h0000_0000, "cleared by start (R3)");

        // R2: junk in unused word bits; R5: odd halt levels are held.
        junk_mask = 32'hF003_C000;
        begin_prog(); wbyte(8'h90); rbyte(1); end_prog(1'b0, 1'b1);
        junk_mask = 32'd0;
        push_byte(8'h96);
        launch(); wait_done();
        check_result(32'h0000_0096, "junk bits ignored (R2)");
        repeat (10) @(posedge clk);

        checking = 1'b0;
        summary();
        $finish;
    end

endmodule